// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a 512-byte serial EEPROM that answers on a two-wire bus (I2C style). A fast system clock oversamples the bus clock and data lines. Dedicated logic spots START and STOP conditions. A shift engine receives the device address, the word address and the data bytes, and acknowledges each one by pulling the open-drain data line low. The block can also shift read data out. A 9-bit pointer tracks the array location. Its top bit comes from the page-select bit of the device address byte.

Written bytes go into a 16-entry page buffer. They are copied into the array only when a STOP closes the write. After that copy, a timed busy window runs for a parameterised number of clock cycles. During that window the slave gives no acknowledge to its own address, so a host can poll it until it is ready. When the lock input is high, the upper 256 bytes cannot be written. Writes aimed at them are still acknowledged, but they leave the array as it was.

Top module: `eep2w_slave`

## Requirements
- R1: After reset the data line is released and every array byte reads as 0x00.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP releases the data line. A START at any point restarts device-address reception and discards unwritten page data.
- R3: The device byte is sent MSB first as 1010, then strap_i[1], then strap_i[0], then the page bit, then the read flag (1 = read). Only a matching byte is acknowledged. A byte that does not match leaves the slave off the bus until the next START.
- R4: In a write, the byte after the device byte is the word address, and the pointer becomes {page bit, word}. Each data byte that follows is acknowledged.
- R5: In a write, the low 4 pointer bits wrap inside the 16-byte page. Sending more than 16 bytes overwrites the buffer entries written earlier.
- R6: A STOP after at least one data byte commits the page and starts a busy window of WR_CYCLES clocks. In that window the device byte gets no acknowledge. A write that carries no data bytes starts no busy window.
- R7: With wp_i high, the upper half (pointer bit 8 = 1) keeps its contents after a write, although every byte is acknowledged. The lower half is written normally.
- R8: A read with no preceding word address starts at the current pointer, with bit 8 taken from the page bit. After a write, the pointer sits on the byte after the last one written, wrapped within the page.
- R9: A word-address write followed by a repeated START and a read returns the byte at that address.
- R10: Reads advance the pointer after each byte and wrap from 511 to 0. A host acknowledge requests the next byte, and a host NACK ends the read.
- R11: The slave changes its data-line drive only while SCL is low, except for the release on STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Data line as seen on the wire |
| strap_i | input | 2 | Address straps: [1] matches device bit 3, [0] matches bit 2 |
| wp_i | input | 1 | High locks the upper 256 bytes |
| sda_pull_o | output | 1 | High pulls the open-drain data line low |

## Verification
Two functions can fall close together. The first pair is the page-buffer fill and its discard by a START. The bench sends a data byte, then only three bits of the next byte, then a repeated START. It judges the result by a read back, with no busy window, showing that the old contents survive. The second pair is the commit at STOP and the address poll that follows it at once. The bench issues the poll straight after each data write. It expects a NACK there, and an acknowledge once the window has run out, while an address-only write is acknowledged at once.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int MEM_BYTES  = 512;
    localparam int ADDR_W     = $clog2(MEM_BYTES);
    localparam int PAGE_BYTES = 16;
    localparam int PAGE_W     = $clog2(PAGE_BYTES);
    localparam int BASE_W     = ADDR_W - PAGE_W;
    localparam logic [3:0] FAMILY_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_WORD, ST_WDATA, ST_ACK, ST_RDATA, ST_RACK
    } xfer_st_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [1:0] strap);
        return (b[7:4] == FAMILY_CODE) && (b[3:2] == strap);
    endfunction
endpackage

// File: rtl/eep_busscan.sv
module eep_busscan
    import eep_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/eep_store.sv
module eep_store
    import eep_pkg::*;
#(
    parameter int WR_CYCLES = 300000,
    localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_din,
    input  logic              commit,
    input  logic              wp,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy_o
);
    logic [7:0]            arr [MEM_BYTES];
    logic [7:0]            pg  [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pg_vld;
    logic [BASE_W-1:0]     pg_base;
    logic [CNT_W-1:0]      wcnt;
    logic                  locked;
    logic                  do_commit;

    assign locked    = wp & pg_base[BASE_W-1];
    assign do_commit = commit & (|pg_vld);

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_vld  <= '0;
            pg_base <= '0;
            wcnt    <= '0;
        end else begin
            if (do_commit) begin
                wcnt   <= CNT_W'(WR_CYCLES);
                pg_vld <= '0;
            end else begin
                if (wcnt != '0)
                    wcnt <= wcnt - 1'b1;
                if (buf_clr) begin
                    pg_vld <= '0;
                end else if (buf_we) begin
                    pg_vld[buf_addr[PAGE_W-1:0]] <= 1'b1;
                    pg_base <= buf_addr[ADDR_W-1:PAGE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we)
            pg[buf_addr[PAGE_W-1:0]] <= buf_din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_BYTES; i++)
                arr[i] <= '0;
        end else if (do_commit && !locked) begin
            for (int s = 0; s < PAGE_BYTES; s++)
                if (pg_vld[s])
                    arr[{pg_base, s[PAGE_W-1:0]}] <= pg[s];
        end
    end

    assign rd_data = arr[rd_addr];
    assign busy_o  = (wcnt != '0);
endmodule

// File: rtl/eep2w_slave.sv
module eep2w_slave
    import eep_pkg::*;
#(
    parameter int WR_CYCLES   = 300000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    input  logic       wp_i,
    output logic       sda_pull_o
);
    bus_ev_t           ev;
    xfer_st_t          st, st_after;
    logic [3:0]        bitcnt;
    logic [7:0]        sh;
    logic [ADDR_W-1:0] ptr;
    logic              page_bit;
    logic              host_ack;
    logic              pull;
    logic              byte_done;
    logic              busy_w;
    logic [7:0]        rd_data;

    eep_busscan #(.STAGES(SYNC_STAGES)) u_scan (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev_o(ev)
    );

    eep_store #(.WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst(rst),
        .buf_clr(ev.start),
        .buf_we(st == ST_WDATA && byte_done),
        .buf_addr(ptr), .buf_din(sh),
        .commit(ev.stop), .wp(wp_i),
        .rd_addr(ptr), .rd_data(rd_data), .busy_o(busy_w)
    );

    assign byte_done  = ev.scl_fall && (bitcnt == 4'd8);
    assign sda_pull_o = pull;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            st_after <= ST_IDLE;
            bitcnt   <= '0;
            sh       <= '0;
            ptr      <= '0;
            page_bit <= 1'b0;
            host_ack <= 1'b0;
            pull     <= 1'b0;
        end else if (ev.start) begin
            st     <= ST_DEV;
            bitcnt <= '0;
            pull   <= 1'b0;
        end else if (ev.stop) begin
            st   <= ST_IDLE;
            pull <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_WORD, ST_WDATA: begin
                    if (ev.scl_rise && bitcnt != 4'd8) begin
                        sh     <= {sh[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_DEV) begin
                            if (dev_hit(sh, strap_i) && !busy_w) begin
                                pull <= 1'b1;
                                st   <= ST_ACK;
                                if (sh[0]) begin
                                    st_after         <= ST_RDATA;
                                    ptr[ADDR_W-1]    <= sh[1];
                                end else begin
                                    st_after <= ST_WORD;
                                    page_bit <= sh[1];
                                end
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            pull     <= 1'b1;
                            st       <= ST_ACK;
                            st_after <= ST_WDATA;
                            if (st == ST_WORD)
                                ptr <= {page_bit, sh};
                            else
                                ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        st     <= st_after;
                        if (st_after == ST_RDATA) begin
                            sh   <= rd_data;
                            pull <= ~rd_data[7];
                            ptr  <= ptr + 1'b1;
                        end else begin
                            pull <= 1'b0;
                        end
                    end
                end
                ST_RDATA: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            pull <= 1'b0;
                            st   <= ST_RACK;
                        end else begin
                            pull   <= ~sh[6];
                            sh     <= {sh[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) begin
                        host_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (host_ack) begin
                            st   <= ST_RDATA;
                            sh   <= rd_data;
                            pull <= ~rd_data[7];
                            ptr  <= ptr + 1'b1;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

module eep2w_slave_chk (
    input logic clk,
    input logic rst,
    input logic sda_pull,
    input logic busy,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic idle
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        idle |-> !sda_pull) else $error("idle slave drives bus"); // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull) else $error("line held after stop"); // R2

    AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (rst)
        busy |-> !$rose(sda_pull)) else $error("ack during busy"); // R6

    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop_det)) else $error("busy without stop"); // R6

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(start_det) && !$past(stop_det)) |-> !$past(scl_s))
        else $error("drive moved with scl high"); // R11
endmodule

bind eep2w_slave eep2w_slave_chk u_chk (
    .clk(clk), .rst(rst), .sda_pull(sda_pull_o), .busy(busy_w),
    .scl_s(ev.scl), .start_det(ev.start), .stop_det(ev.stop),
    .idle(st == ST_IDLE)
);

// File: tb/eep2w_slave_tb.sv
module eep2w_slave_tb;
    localparam int CLK_P = 10;
    localparam int Q     = 16;
    localparam int WRC   = 2000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       sda_pull;
    logic       sda_line;

    assign sda_line = m_sda & ~sda_pull;

    eep2w_slave #(.WR_CYCLES(WRC)) u_dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
        .strap_i(strap), .wp_i(wp), .sda_pull_o(sda_pull)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int r11_bad = 0;
    bit done = 0;
    int mem_m [512];
    int addr_m = 0;
    int pend_q[$];

    task automatic check(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // R11 monitor: compared on every clock
    logic prev_pull = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_pull != prev_pull && m_scl) r11_bad++;
        prev_pull = sda_pull;
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1; tick(Q); m_scl = 1; tick(Q); m_sda = 0; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(Q); m_scl = 1; tick(Q); m_sda = 1; tick(Q);
    endtask

    task automatic send_bit(bit b);
        m_sda = b; tick(Q); m_scl = 1; tick(2*Q); m_scl = 0; tick(Q);
    endtask

    task automatic recv_bit(output bit b);
        m_sda = 1; tick(Q); m_scl = 1; tick(Q); b = sda_line; tick(Q); m_scl = 0; tick(Q);
    endtask

    task automatic send_byte(int v, output bit ack);
        bit b;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output int v, input bit give_ack);
        bit b;
        v = 0;
        for (int i = 0; i < 8; i++) begin recv_bit(b); v = (v << 1) | b; end
        send_bit(~give_ack);
    endtask

    function automatic int devb(int p0, int rd);
        return (4'b1010 << 4) | (strap << 2) | (p0 << 1) | rd;
    endfunction

    task automatic poll(bit exp_ack, string tag);
        bit a;
        bus_start(); send_byte(devb(0, 0), a); bus_stop();
        check(tag, a, exp_ack);
    endtask

    task automatic wr_txn(int a, int n, int seed, string tag);
        bit k; int d;
        bus_start();
        send_byte(devb((a >> 8) & 1, 0), k); check({tag, " dev ack"}, k, 1);
        send_byte(a & 255, k);               check({tag, " word ack"}, k, 1);
        pend_q.delete();
        for (int i = 0; i < n; i++) begin
            d = (seed + i * 37) & 255;
            send_byte(d, k); check({tag, " data ack"}, k, 1);
            pend_q.push_back(((a & 'h1F0) | ((a + i) & 15)) << 8 | d);
        end
        bus_stop();
        if (!(wp && (a & 'h100)))
            foreach (pend_q[j]) mem_m[pend_q[j] >> 8] = pend_q[j] & 255;
        addr_m = (a & 'h1F0) | ((a + n) & 15);
    endtask

    task automatic rd_seq(int n, int p0, string tag);
        bit k; int v;
        bus_start();
        send_byte(devb(p0, 1), k); check({tag, " rd dev ack"}, k, 1);
        addr_m = (p0 << 8) | (addr_m & 255);
        for (int i = 0; i < n; i++) begin
            recv_byte(v, i != n - 1);
            check(tag, v, mem_m[addr_m]);
            addr_m = (addr_m + 1) % 512;
        end
        bus_stop();
    endtask

    task automatic rnd_read(int a, int n, string tag);
        bit k;
        bus_start();
        send_byte(devb((a >> 8) & 1, 0), k); check({tag, " dev ack"}, k, 1);
        send_byte(a & 255, k);               check({tag, " word ack"}, k, 1);
        addr_m = a;
        rd_seq(n, (a >> 8) & 1, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        bit k;
        foreach (mem_m[i]) mem_m[i] = 0;
        tick(5); rst = 0; tick(5);
        check("R1 pull after reset", sda_pull, 0);
        rnd_read('h000, 2, "R1 R9 cleared array");

        wr_txn('h005, 1, 'h11, "R4 byte write");
        poll(0, "R6 nack while busy");
        tick(WRC);
        poll(1, "R6 ack after busy");
        rnd_read('h005, 1, "R9 R4 readback");

        wr_txn('h1F3, 19, 'h40, "R5 page wrap");
        poll(0, "R6 busy after page");
        tick(WRC);
        rd_seq(1, 1, "R8 current after page");
        rnd_read('h1F0, 16, "R5 R10 page readback");

        wp = 1;
        wr_txn('h150, 2, 'h80, "R7 locked write");
        tick(WRC);
        rnd_read('h150, 2, "R7 upper unchanged");
        wr_txn('h050, 2, 'h90, "R7 lower write");
        tick(WRC);
        rnd_read('h050, 2, "R7 lower written");
        wp = 0;

        bus_start(); send_byte((4'b1010 << 4) | ((~strap & 3) << 2), k); bus_stop();
        check("R3 wrong strap nack", k, 0);
        bus_start(); send_byte((4'b1011 << 4) | (strap << 2), k); bus_stop();
        check("R3 wrong family nack", k, 0);
        poll(1, "R3 match ack");

        wr_txn('h0AA, 0, 0, "R6 address only");
        poll(1, "R6 no busy without data");
        rd_seq(1, 0, "R8 current read");

        wr_txn('h1FE, 2, 'hC0, "R10 wrap prep");
        tick(WRC);
        rnd_read('h1FE, 4, "R10 wrap 511 to 0");

        // R2: restart mid-byte discards buffered data
        bus_start();
        send_byte(devb(0, 0), k); check("R2 dev ack", k, 1);
        send_byte('h20, k);       check("R2 word ack", k, 1);
        send_byte('h5A, k);       check("R2 data ack", k, 1);
        send_bit(1); send_bit(0); send_bit(1);
        addr_m = 'h021;
        rd_seq(1, 0, "R2 read after restart");
        poll(1, "R2 no busy after discard");
        rnd_read('h020, 1, "R2 data discarded");

        check("R11 drive moved with scl high", r11_bad, 0);
        done = 1;
        finish_run();
    end
endmodule